// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block forms the status word a host sees when it reads a flash device while an embedded program or erase is running. The command logic tells it which operation is under way. It also supplies bit 7 of the byte being programmed, the sectors chosen for erase, whether the window for adding sectors is still open, and a pulse when the internal pulse-count limit is exceeded. The block watches the chip-enable and output-enable strobes and the read address. From these it returns either the status word or the array data it is given.

Both toggle bits advance once per read access, not with time. Q6 inverts on every read while an operation is active. Q2 inverts only on reads that fall inside a sector chosen for erase, which lets the host tell which sectors are erasing. A program aimed at a protected sector starts a short fixed window. During that window Q6 toggles and the block reports busy, and afterwards array reads resume. A ready output is low whenever the device is actively programming or erasing.

Top module: `flash_op_status`

## Requirements
- R1: For one clock cycle with `rst` high, `ready` is 1, `status_dq` equals `array_dq` in read mode, and bit 5 is cleared.
- R2: In program mode (`op_mode`=1), `ready` is 0 and `status_dq` bit 7 is the inverse of `prog_d7`. Bits 4, 3, 2, 1 and 0 read 0, and bit 5 is the sticky limit flag.
- R3: A read starts on the cycle where `ce_n` and `oe_n` are both low after not both being low. In program, erase or suspend-program mode, or during the protect window, bit 6 inverts on each read start at any address. Bit 6 does not change while a read is held, nor in any other mode.
- R4: In erase mode (`op_mode`=2), `ready` is 0 and bit 7 reads 0. Bit 3 reads 0 while `window_open` is 1 and reads 1 once it is 0.
- R5: The sector of a read is `rd_addr[ADDR_W-1 -: SECT_BITS]`, and it is selected when `erase_sel[sector]` is 1. In erase or suspend mode, bit 2 inverts on each read start at a selected sector. It is unchanged by reads of unselected sectors.
- R6: In suspend mode (`op_mode`=3), `ready` is 1 and bit 6 does not toggle. A selected-sector read returns bit 7 = 1 with bit 2 toggling. An unselected-sector read returns `array_dq`.
- R7: In suspend-program mode (`op_mode`=4), `ready` is 0 and the status word follows the R2 layout.
- R8: A one-cycle `limit_hit` pulse sets bit 5. Bit 5 stays set in every later status word until `rst`.
- R9: A `prot_start` pulse in read mode opens a window of `PROT_CYCLES` clock cycles. During the window `ready` is 0 and reads give the R2 word with bit 6 toggling. After the window, reads return `array_dq` and `ready` is 1.
- R10: In read mode (`op_mode`=0) outside the protect window, `status_dq` equals `array_dq` and the toggle bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 3 | Operation state: 0 read, 1 program, 2 erase, 3 suspended, 4 suspend-program |
| prog_d7 | input | 1 | Bit 7 of the byte being programmed |
| rd_addr | input | ADDR_W | Read address |
| erase_sel | input | 2**SECT_BITS | Sectors chosen for erase, one bit per sector |
| window_open | input | 1 | Add-sector window still open |
| limit_hit | input | 1 | Pulse-count limit exceeded |
| prot_start | input | 1 | Program aimed at a protected sector |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| array_dq | input | 8 | Array read data |
| status_dq | output | 8 | Status word or array data |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
The toggle flops update on the clock edge that first sees both strobes low, and the output word is combinational from registered state. A toggled bit is therefore visible one clock edge after the read starts. Each read in the bench lowers the strobes at a falling edge and samples the word at the next falling edge. It then raises the strobes for one full cycle so that the next read is a fresh start.

Mode changes, the sticky limit flag and the protect window all take effect one edge after the input changes, and they are sampled a cycle later. The end of the protect window is checked after waiting well past `PROT_CYCLES` edges.

// File: rtl/osr_pkg.sv
package osr_pkg;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_PROG      = 3'd1,
        OP_ERASE     = 3'd2,
        OP_SUSP      = 3'd3,
        OP_SUSP_PROG = 3'd4
    } op_mode_e;

    localparam int POLL_BIT   = 7;
    localparam int TOG_BIT    = 6;
    localparam int LIMIT_BIT  = 5;
    localparam int WINDOW_BIT = 3;
    localparam int SECTOG_BIT = 2;

    function automatic logic is_prog_like(input op_mode_e m);
        return (m == OP_PROG) || (m == OP_SUSP_PROG);
    endfunction

    function automatic logic is_busy_mode(input op_mode_e m);
        return (m == OP_PROG) || (m == OP_SUSP_PROG) || (m == OP_ERASE);
    endfunction

endpackage

// File: rtl/osr_toggle.sv
module osr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic rd_active,
    input  logic t6_en,
    input  logic t2_en,
    output logic t6,
    output logic t2
);
    logic rd_prev;
    logic rd_start;

    assign rd_start = rd_active & ~rd_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev <= 1'b0;
            t6      <= 1'b0;
            t2      <= 1'b0;
        end else begin
            rd_prev <= rd_active;
            if (rd_start && t6_en) t6 <= ~t6;
            if (rd_start && t2_en) t2 <= ~t2;
        end
    end

    // R3: each new read in an active mode flips bit 6
    p_q6_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_active && !rd_prev && t6_en) |=> (t6 != $past(t6)));

    // R3: held or absent reads leave bit 6 alone
    p_q6_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(rd_active && !rd_prev) |=> $stable(t6));

    // R5: bit 2 moves only when enabled
    p_q2_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !t2_en |=> $stable(t2));
endmodule

// File: rtl/osr_prot_timer.sv
module osr_prot_timer #(
    parameter int CYCLES = 250,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= CNT_W'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R9: window counts down one per cycle until it closes
    p_window_count_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/osr_word_mux.sv
module osr_word_mux
    import osr_pkg::*;
(
    input  op_mode_e    mode,
    input  logic        prot_busy,
    input  logic        sel_hit,
    input  logic        prog_d7,
    input  logic        t6,
    input  logic        t2,
    input  logic        q5,
    input  logic        window_open,
    input  logic [7:0]  array_dq,
    output logic [7:0]  word
);
    always_comb begin
        word = '0;
        word[LIMIT_BIT] = q5;
        unique case (mode)
            OP_PROG, OP_SUSP_PROG: begin
                word[POLL_BIT] = ~prog_d7;
                word[TOG_BIT]  = t6;
            end
            OP_ERASE: begin
                word[POLL_BIT]   = 1'b0;
                word[TOG_BIT]    = t6;
                word[WINDOW_BIT] = ~window_open;
                word[SECTOG_BIT] = t2;
            end
            OP_SUSP: begin
                if (sel_hit) begin
                    word[POLL_BIT]   = 1'b1;
                    word[TOG_BIT]    = t6;
                    word[SECTOG_BIT] = t2;
                end else begin
                    word = array_dq;
                end
            end
            default: begin
                if (prot_busy) begin
                    word[POLL_BIT] = ~prog_d7;
                    word[TOG_BIT]  = t6;
                end else begin
                    word = array_dq;
                end
            end
        endcase
    end
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
    import osr_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int SECT_BITS   = 3,
    parameter int PROT_CYCLES = 250,
    localparam int NUM_SECT   = 1 << SECT_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          op_mode,
    input  logic                prog_d7,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_SECT-1:0] erase_sel,
    input  logic                window_open,
    input  logic                limit_hit,
    input  logic                prot_start,
    input  logic                ce_n,
    input  logic                oe_n,
    input  logic [7:0]          array_dq,
    output logic [7:0]          status_dq,
    output logic                ready
);
    op_mode_e             mode;
    logic [SECT_BITS-1:0] sect;
    logic                 sel_hit;
    logic                 prot_busy;
    logic                 t6, t2, q5;
    logic                 t6_en, t2_en;
    logic                 read_mode;

    assign mode      = op_mode_e'(op_mode);
    assign sect      = rd_addr[ADDR_W-1 -: SECT_BITS];
    assign sel_hit   = erase_sel[sect];
    assign read_mode = (mode == OP_READ);
    assign t6_en     = is_busy_mode(mode) || (read_mode && prot_busy);
    assign t2_en     = sel_hit && (mode == OP_ERASE || mode == OP_SUSP);

    always_ff @(posedge clk) begin
        if (rst)            q5 <= 1'b0;
        else if (limit_hit) q5 <= 1'b1;
    end

    osr_prot_timer #(.CYCLES(PROT_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(prot_start), .busy(prot_busy)
    );

    osr_toggle u_tog (
        .clk(clk), .rst(rst), .rd_active(!ce_n && !oe_n),
        .t6_en(t6_en), .t2_en(t2_en), .t6(t6), .t2(t2)
    );

    osr_word_mux u_mux (
        .mode(mode), .prot_busy(prot_busy), .sel_hit(sel_hit),
        .prog_d7(prog_d7), .t6(t6), .t2(t2), .q5(q5),
        .window_open(window_open), .array_dq(array_dq), .word(status_dq)
    );

    assign ready = !(is_busy_mode(mode) || (read_mode && prot_busy));

    // R8: limit flag never drops without reset
    p_limit_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        q5 |=> q5);

    // R2: program reports busy and inverted poll bit
    p_prog_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == OP_PROG) |-> (!ready && status_dq[POLL_BIT] == !prog_d7));

    // R4: erase reads 0 on the poll bit
    p_erase_poll_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == OP_ERASE) |-> (!ready && !status_dq[POLL_BIT]));

    // R6: suspended device reports ready
    p_susp_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == OP_SUSP) |-> ready);

    // R10: plain read mode passes array data
    p_read_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (read_mode && !prot_busy) |-> (status_dq == array_dq));
endmodule

// File: tb/tb_flash_op_status.sv
module tb_flash_op_status;
    localparam int ADDR_W = 18;
    localparam int SB     = 3;
    localparam int PC     = 20;

    logic clk = 0;
    logic rst;
    logic [2:0] op_mode;
    logic prog_d7, window_open, limit_hit, prot_start, ce_n, oe_n;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0] erase_sel, array_dq, status_dq;
    logic ready;

    int checks = 0;
    int errors = 0;
    logic [7:0] r1, r2, r3;

    always #4 clk = ~clk;

    flash_op_status #(.ADDR_W(ADDR_W), .SECT_BITS(SB), .PROT_CYCLES(PC)) dut (
        .clk(clk), .rst(rst), .op_mode(op_mode), .prog_d7(prog_d7),
        .rd_addr(rd_addr), .erase_sel(erase_sel), .window_open(window_open),
        .limit_hit(limit_hit), .prot_start(prot_start), .ce_n(ce_n), .oe_n(oe_n),
        .array_dq(array_dq), .status_dq(status_dq), .ready(ready)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] sa(input int s);
        return ADDR_W'(s) << (ADDR_W - SB);
    endfunction

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        rd_addr = a; ce_n = 0; oe_n = 0;
        @(negedge clk);
        d = status_dq;
        ce_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [2:0] m);
        op_mode = m;
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset;
        do_reset();
        op_mode = 0; array_dq = 8'h5A;
        @(negedge clk);
        chk("R1 ready", {7'd0, ready}, 8'd1);
        chk("R1 data", status_dq, 8'h5A);
        set_mode(1); prog_d7 = 1;
        #1 chk("R1 q5 clear", status_dq & 8'h20, 8'h00);
        set_mode(0);
    endtask

    task automatic t_prog;
        prog_d7 = 1; set_mode(1);
        chk("R2 busy", {7'd0, ready}, 8'd0);
        rd(sa(1), r1); rd(sa(6), r2);
        chk("R2 q7", r1 & 8'h80, 8'h00);
        chk("R2 low bits", r1 & 8'h1F, 8'h00);
        chk("R3 q6 toggles prog", (r1 ^ r2) & 8'h40, 8'h40);
        prog_d7 = 0; #1;
        chk("R2 q7 inverted", status_dq & 8'h80, 8'h80);
        // held read: single toggle only
        ce_n = 0; oe_n = 0;
        @(negedge clk); r1 = status_dq;
        @(negedge clk); @(negedge clk); r2 = status_dq;
        ce_n = 1; oe_n = 1; @(negedge clk);
        chk("R3 held read no toggle", r1 & 8'h40, r2 & 8'h40);
        set_mode(0);
    endtask

    task automatic t_erase;
        erase_sel = 8'b0000_0100; window_open = 1; set_mode(2);
        chk("R4 busy", {7'd0, ready}, 8'd0);
        rd(sa(2), r1);
        chk("R4 q7 zero", r1 & 8'h80, 8'h00);
        chk("R4 q3 window open", r1 & 8'h08, 8'h00);
        rd(sa(2), r2);
        chk("R5 q2 toggles selected", (r1 ^ r2) & 8'h04, 8'h04);
        chk("R3 q6 toggles erase", (r1 ^ r2) & 8'h40, 8'h40);
        rd(sa(5), r3);
        chk("R5 q2 steady unselected", r3 & 8'h04, r2 & 8'h04);
        rd(sa(7), r1);
        chk("R5 q2 steady unselected 2", r1 & 8'h04, r3 & 8'h04);
        window_open = 0; #1;
        chk("R4 q3 started", status_dq & 8'h08, 8'h08);
    endtask

    task automatic t_susp;
        array_dq = 8'h3C; set_mode(3);
        chk("R6 ready", {7'd0, ready}, 8'd1);
        rd(sa(2), r1); rd(sa(2), r2);
        chk("R6 q7 one", r1 & 8'h80, 8'h80);
        chk("R6 q6 frozen", (r1 ^ r2) & 8'h40, 8'h00);
        chk("R5 q2 toggles suspended", (r1 ^ r2) & 8'h04, 8'h04);
        rd(sa(4), r3);
        chk("R6 unselected array", r3, 8'h3C);
        prog_d7 = 0; set_mode(4);
        chk("R7 busy", {7'd0, ready}, 8'd0);
        rd(sa(4), r1); rd(sa(4), r2);
        chk("R7 q7", r1 & 8'h80, 8'h80);
        chk("R7 q6 toggles", (r1 ^ r2) & 8'h40, 8'h40);
        chk("R7 low bits", r1 & 8'h1F, 8'h00);
        set_mode(0);
    endtask

    task automatic t_limit;
        set_mode(1);
        limit_hit = 1; @(negedge clk); limit_hit = 0;
        rd(sa(0), r1);
        chk("R8 q5 set", r1 & 8'h20, 8'h20);
        set_mode(0); set_mode(2); window_open = 0;
        repeat (5) @(negedge clk);
        chk("R8 q5 held", status_dq & 8'h20, 8'h20);
        set_mode(0);
        do_reset(); set_mode(1);
        chk("R8 q5 cleared", status_dq & 8'h20, 8'h00);
        set_mode(0);
    endtask

    task automatic t_prot;
        array_dq = 8'hC3; op_mode = 0; prog_d7 = 1;
        rd(sa(3), r1);
        rd(sa(3), r2);
        chk("R10 read passthrough", r2, 8'hC3);
        prot_start = 1; @(negedge clk); prot_start = 0;
        chk("R9 busy", {7'd0, ready}, 8'd0);
        rd(sa(3), r1); rd(sa(3), r2);
        chk("R9 q7", r1 & 8'h80, 8'h00);
        chk("R9 q6 toggles", (r1 ^ r2) & 8'h40, 8'h40);
        repeat (PC + 4) @(negedge clk);
        chk("R9 ready after", {7'd0, ready}, 8'd1);
        rd(sa(3), r3);
        chk("R9 array after", r3, 8'hC3);
    endtask

    initial begin
        rst = 1; op_mode = 0; prog_d7 = 0; rd_addr = '0; erase_sel = '0;
        window_open = 1; limit_hit = 0; prot_start = 0; ce_n = 1; oe_n = 1;
        array_dq = 0;
        @(negedge clk);
        t_reset();
        t_prog();
        t_erase();
        t_susp();
        t_limit();
        t_prot();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule